// File: doc/BRIEF.md
# Trap and Privilege Controller

This block is the trap unit of a small in-order processor. It keeps a one-bit privilege level (0 = user, 1 = kernel), a trap-enable flag, the exception PC (EPC), a cause code, a faulting-address register and a programmable tick timer. The pipeline reports synchronous requests for its oldest unfinished instruction: system call, arithmetic fault, bad address, or an instruction that needs kernel rights. The timer raises an interrupt every N cycles. When a trap is taken, the block does everything in one clock edge. It records EPC and the cause, saves the old level and the current stack pointer, raises the level to kernel, masks further traps, and asks the pipeline to flush and fetch from the handler vector. In the same cycle it asks the register file to load the kernel stack pointer.

A return command issued in kernel mode reverses the entry. It restores the saved level, hands back the saved stack pointer and fetches from EPC. It also re-enables traps. The same mechanism starts user programs after boot: reset leaves the block in kernel mode with the saved level at user. Kernel software therefore writes the program entry into EPC and issues a return. The system-call service number stays in the register file and is never touched here.

Top module: `trap_ctrl`

## Requirements
- R1: While reset is asserted and for the first cycle after its release, `redirect` is 1 with `redirect_pc` equal to `BOOT_ADDR`, and `mode` is 1. In the next cycle `redirect` is 0. Traps are enabled and the timer period is 0.
- R2: A trap that is taken raises `redirect` and `sp_wr` in the same cycle, with `redirect_pc` equal to `VEC_ADDR` and `sp_wdata` equal to `KSTACK`. From the next cycle `mode` is 1. A synchronous trap sets EPC to `op_pc`.
- R3: Cause codes are 10 for a privilege violation, 4 for a bad address, 12 for an arithmetic fault, 8 for a system call and 0 for a timer interrupt. When several synchronous requests are raised together, the priority is 10 over 4 over 12 over 8.
- R4: A synchronous request beats a pending interrupt in the same cycle, and the interrupt stays pending. A taken interrupt sets EPC to `next_pc`.
- R5: While traps are masked, requests cause no redirect and leave EPC and Cause unchanged. A timer tick stays pending and is taken in the first cycle after the return that re-enables traps.
- R6: A return in kernel mode raises `redirect` with `redirect_pc` equal to EPC, and raises `sp_wr` with `sp_wdata` equal to the stack pointer saved at entry. From the next cycle the saved level is in effect and traps are enabled. The saved level is 0 after reset.
- R7: In user mode, any CSR access, any return command and any `req_priv` takes a trap with cause 10. In this case `csr_rdata` reads 0 and the CSR write is dropped.
- R8: In kernel mode, `req_priv` causes no trap. CSR selects are 0 = EPC, 1 = Cause (low 4 bits), 2 = timer period (low `TW` bits) and 3 = faulting address (read only). Writes take effect at the clock edge and reads are combinational.
- R9: After a period N other than 0 is written, the interrupt becomes pending at the Nth clock edge after the write, then every N edges. A period of 0 stops the timer.
- R10: The faulting-address register loads `fault_addr` only when a trap with cause 4 is taken, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_syscall | input | 1 | Oldest instruction is a system call |
| req_arith | input | 1 | Oldest instruction raised an arithmetic fault |
| req_badaddr | input | 1 | Oldest instruction raised an address fault |
| req_priv | input | 1 | Oldest instruction needs kernel rights |
| op_pc | input | XLEN | PC of the oldest unfinished instruction |
| fault_addr | input | XLEN | Offending data address |
| next_pc | input | XLEN | PC at which to resume after an interrupt |
| cur_sp | input | XLEN | Current stack pointer value |
| eret | input | 1 | Return-from-trap command |
| csr_en | input | 1 | CSR access by the oldest instruction |
| csr_we | input | 1 | CSR access is a write |
| csr_sel | input | 2 | CSR select |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| mode | output | 1 | Privilege level, 1 = kernel |
| redirect | output | 1 | Flush the younger instructions and fetch from `redirect_pc` |
| redirect_pc | output | XLEN | Fetch target |
| sp_wr | output | 1 | Load the stack pointer |
| sp_wdata | output | XLEN | New stack pointer value |

## Verification
The bound checker watches a set of invariants on every cycle. Each taken trap must leave the block in kernel mode with traps masked. EPC and Cause must stay fixed while traps are masked, unless kernel software writes them. A pending tick must persist until it is taken. A user CSR access must end with cause 10, and a return must restore the saved level. The faulting-address register must move only on cause-4 entries. The bench scenarios cover what only ordered stimulus can show: the priority order over every combination of synchronous requests, the exact cycle of each timer tick for a sweep of periods, the stack-pointer round trip through entry and return, and a tick that arrives while masked and is taken right after the return.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int XLEN = 32,
  parameter int TW = 8,
  parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0000_0100,
  parameter logic [XLEN-1:0] VEC_ADDR  = 32'h0000_0080,
  parameter logic [XLEN-1:0] KSTACK    = 32'h8000_fff0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_syscall,
  input  logic            req_arith,
  input  logic            req_badaddr,
  input  logic            req_priv,
  input  logic [XLEN-1:0] op_pc,
  input  logic [XLEN-1:0] fault_addr,
  input  logic [XLEN-1:0] next_pc,
  input  logic [XLEN-1:0] cur_sp,
  input  logic            eret,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            mode,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            sp_wr,
  output logic [XLEN-1:0] sp_wdata
);
  localparam logic [3:0] C_IRQ = 4'd0, C_ADDR = 4'd4, C_SYS = 4'd8,
                         C_PRIV = 4'd10, C_ARITH = 4'd12;

  logic            mode_q, ie, saved_mode, boot, irq_pend;
  logic [XLEN-1:0] saved_sp, epc, badaddr;
  logic [3:0]      cause;
  logic [TW-1:0]   period, cnt;

  logic       priv_bad, sync_hit, take_sync, take_irq, take, do_eret;
  logic       csr_wr_ok, period_wr, tick;
  logic [3:0] sync_code;

  assign priv_bad  = !mode_q && (req_priv || csr_en || eret);
  assign sync_hit  = priv_bad || req_badaddr || req_arith || req_syscall;
  assign sync_code = priv_bad    ? C_PRIV :
                     req_badaddr ? C_ADDR :
                     req_arith   ? C_ARITH : C_SYS;
  assign do_eret   = !boot && mode_q && eret && !sync_hit;
  assign take_sync = !boot && ie && sync_hit;
  assign take_irq  = !boot && ie && !sync_hit && !do_eret && irq_pend;
  assign take      = take_sync || take_irq;
  assign csr_wr_ok = !boot && mode_q && csr_en && csr_we && !take;
  assign period_wr = csr_wr_ok && csr_sel == 2'd2;
  assign tick      = period != '0 && cnt == period - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b1; ie <= 1'b1; boot <= 1'b1; saved_mode <= 1'b0;
      irq_pend <= 1'b0; saved_sp <= '0; epc <= '0; badaddr <= '0;
      cause <= '0; period <= '0; cnt <= '0;
    end else begin
      boot <= 1'b0;
      if (period_wr || tick) cnt <= '0;
      else if (period != '0) cnt <= cnt + 1'b1;
      irq_pend <= (irq_pend && !take_irq) || tick;
      if (take) begin
        epc        <= take_irq ? next_pc : op_pc;
        cause      <= take_irq ? C_IRQ : sync_code;
        saved_mode <= mode_q;
        saved_sp   <= cur_sp;
        mode_q     <= 1'b1;
        ie         <= 1'b0;
        if (take_sync && sync_code == C_ADDR) badaddr <= fault_addr;
      end else if (do_eret) begin
        mode_q <= saved_mode;
        ie     <= 1'b1;
      end else if (csr_wr_ok) begin
        case (csr_sel)
          2'd0:    epc    <= csr_wdata;
          2'd1:    cause  <= csr_wdata[3:0];
          2'd2:    period <= csr_wdata[TW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (mode_q && csr_en)
      case (csr_sel)
        2'd0:    csr_rdata = epc;
        2'd1:    csr_rdata = {{(XLEN-4){1'b0}}, cause};
        2'd2:    csr_rdata = {{(XLEN-TW){1'b0}}, period};
        default: csr_rdata = badaddr;
      endcase
  end

  assign mode        = mode_q;
  assign redirect    = boot || take || do_eret;
  assign redirect_pc = boot ? BOOT_ADDR : (take ? VEC_ADDR : epc);
  assign sp_wr       = take || do_eret;
  assign sp_wdata    = take ? KSTACK : saved_sp;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_q,
  input logic            ie,
  input logic            boot,
  input logic            saved_mode,
  input logic            irq_pend,
  input logic            take,
  input logic            take_irq,
  input logic            take_sync,
  input logic            do_eret,
  input logic            csr_wr_ok,
  input logic            csr_en,
  input logic [3:0]      sync_code,
  input logic [3:0]      cause,
  input logic [XLEN-1:0] epc,
  input logic [XLEN-1:0] badaddr
);
  assert_trap_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mode_q && !ie));

  assert_masked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !csr_wr_ok) |=> ($stable(epc) && $stable(cause)));

  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !take_irq) |=> irq_pend);

  assert_eret_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_eret |=> (mode_q == $past(saved_mode) && ie));

  assert_user_csr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && csr_en && ie && !boot) |=> (cause == 4'd10 && mode_q));

  assert_badaddr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_sync && sync_code == 4'd4) |=> $stable(badaddr));
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .ie(ie), .boot(boot),
  .saved_mode(saved_mode), .irq_pend(irq_pend), .take(take),
  .take_irq(take_irq), .take_sync(take_sync), .do_eret(do_eret),
  .csr_wr_ok(csr_wr_ok), .csr_en(csr_en), .sync_code(sync_code),
  .cause(cause), .epc(epc), .badaddr(badaddr)
);

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BOOT = 32'h0000_0100, VEC = 32'h0000_0080,
                          KSP = 32'h8000_fff0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_syscall, req_arith, req_badaddr, req_priv, eret, csr_en, csr_we;
  logic [1:0]  csr_sel;
  logic [31:0] op_pc, fault_addr, next_pc, cur_sp, csr_wdata;
  logic [31:0] csr_rdata, redirect_pc, sp_wdata;
  logic        mode, redirect, sp_wr;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_syscall(req_syscall), .req_arith(req_arith),
    .req_badaddr(req_badaddr), .req_priv(req_priv), .op_pc(op_pc),
    .fault_addr(fault_addr), .next_pc(next_pc), .cur_sp(cur_sp), .eret(eret),
    .csr_en(csr_en), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .mode(mode), .redirect(redirect),
    .redirect_pc(redirect_pc), .sp_wr(sp_wr), .sp_wdata(sp_wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_syscall = 0; req_arith = 0; req_badaddr = 0; req_priv = 0; eret = 0;
    csr_en = 0; csr_we = 0; csr_sel = 0; csr_wdata = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle(); rst_n = 0; op_pc = 0; fault_addr = 0; next_pc = 0; cur_sp = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    csr_en = 1; csr_we = 0; csr_sel = s; #1 v = csr_rdata;
    step(); idle();
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    csr_en = 1; csr_we = 1; csr_sel = s; csr_wdata = d;
    step(); idle();
  endtask

  task automatic do_eret(output logic [31:0] pc, output logic [31:0] sp, output logic r);
    eret = 1; #1 pc = redirect_pc; sp = sp_wdata; r = redirect && sp_wr;
    step(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, pc, sp, exp_bad;
    logic r;
    do_reset();
    #1;
    chk(redirect && redirect_pc == BOOT, "R1 boot redirect", redirect_pc, BOOT);
    chk(mode == 1'b1, "R1 reset mode", {31'b0, mode}, 1);
    step();
    chk(!redirect, "R1 boot one cycle", {31'b0, redirect}, 0);

    req_priv = 1; #1
    chk(!redirect, "R8 kernel priv no trap", {31'b0, redirect}, 0);
    step(); idle();
    wr(2'd1, 32'd3); rd(2'd1, v);
    chk(v == 32'd3, "R8 cause rw", v, 3);
    wr(2'd0, 32'h400); rd(2'd0, v);
    chk(v == 32'h400, "R8 epc rw", v, 32'h400);
    r = 0;
    for (int i = 0; i < 10; i++) begin #1 r = r | redirect; step(); end
    chk(!r, "R9 period zero no tick", {31'b0, r}, 0);
    do_eret(pc, sp, r);
    chk(r && pc == 32'h400, "R6 eret to entry", pc, 32'h400);
    chk(sp == 32'h0, "R6 reset saved sp", sp, 0);
    chk(mode == 1'b0, "R6 user after eret", {31'b0, mode}, 0);

    exp_bad = 0;
    for (int m = 1; m < 16; m++) begin
      logic [31:0] opc, fa, usp;
      logic [3:0] ec;
      opc = 32'h1000 + m * 16; fa = 32'hbad0_0000 + m; usp = 32'h7000_0000 + m;
      ec = m[3] ? 4'd10 : m[2] ? 4'd4 : m[1] ? 4'd12 : 4'd8;
      if (ec == 4'd4) exp_bad = fa;
      req_syscall = m[0]; req_arith = m[1]; req_badaddr = m[2]; req_priv = m[3];
      op_pc = opc; fault_addr = fa; cur_sp = usp; #1
      chk(redirect && redirect_pc == VEC, "R2 vector", redirect_pc, VEC);
      chk(sp_wr && sp_wdata == KSP, "R2 kernel stack", sp_wdata, KSP);
      step(); idle(); cur_sp = KSP;
      chk(mode == 1'b1, "R2 kernel mode", {31'b0, mode}, 1);
      rd(2'd0, v); chk(v == opc, "R2 epc", v, opc);
      rd(2'd1, v); chk(v == {28'b0, ec}, "R3 cause priority", v, {28'b0, ec});
      rd(2'd3, v); chk(v == exp_bad, "R10 badaddr", v, exp_bad);
      req_badaddr = 1; op_pc = 32'hdead; fault_addr = 32'hffff; #1
      chk(!redirect, "R5 masked request", {31'b0, redirect}, 0);
      step(); idle();
      rd(2'd0, v); chk(v == opc, "R5 epc kept", v, opc);
      rd(2'd3, v); chk(v == exp_bad, "R10 badaddr kept", v, exp_bad);
      do_eret(pc, sp, r);
      chk(r && pc == opc, "R6 return pc", pc, opc);
      chk(sp == usp, "R6 return sp", sp, usp);
      chk(mode == 1'b0, "R6 user mode back", {31'b0, mode}, 0);
    end

    csr_en = 1; csr_we = 1; csr_sel = 0; csr_wdata = 32'h5555; op_pc = 32'h2000; #1
    chk(csr_rdata == 0, "R7 user read zero", csr_rdata, 0);
    chk(redirect && redirect_pc == VEC, "R7 user csr trap", redirect_pc, VEC);
    step(); idle();
    rd(2'd1, v); chk(v == 32'd10, "R7 cause", v, 10);
    rd(2'd0, v); chk(v == 32'h2000, "R7 write dropped", v, 32'h2000);
    do_eret(pc, sp, r);
    eret = 1; op_pc = 32'h2004; #1
    chk(redirect && redirect_pc == VEC, "R7 user eret trap", redirect_pc, VEC);
    step(); idle();
    rd(2'd1, v); chk(v == 32'd10, "R7 eret cause", v, 10);
    do_eret(pc, sp, r);
    chk(pc == 32'h2004, "R7 eret return", pc, 32'h2004);

    req_syscall = 1; op_pc = 32'h3000; step(); idle();
    wr(2'd2, 32'd2);
    repeat (6) step();
    do_eret(pc, sp, r);
    chk(r && pc == 32'h3000, "R5 eret before pending irq", pc, 32'h3000);
    req_arith = 1; op_pc = 32'h3004; next_pc = 32'h3008; #1
    chk(redirect && redirect_pc == VEC, "R4 sync taken", redirect_pc, VEC);
    step(); idle();
    rd(2'd1, v); chk(v == 32'd12, "R4 sync beats irq", v, 12);
    rd(2'd0, v); chk(v == 32'h3004, "R4 sync epc", v, 32'h3004);
    do_eret(pc, sp, r);
    next_pc = 32'h3010; #1
    chk(redirect && redirect_pc == VEC, "R5 irq after return", redirect_pc, VEC);
    step();
    rd(2'd1, v); chk(v == 32'd0, "R4 irq cause", v, 0);
    rd(2'd0, v); chk(v == 32'h3010, "R4 irq epc", v, 32'h3010);

    for (int n = 1; n <= 6; n++) begin
      int j, e2;
      do_reset(); step();
      next_pc = 32'h500 + n;
      wr(2'd2, n);
      j = 1; #1;
      while (!redirect && j < 40) begin step(); j++; #1; end
      chk(j == n + 1, "R9 first tick", j, n + 1);
      step();
      rd(2'd0, v); chk(v == 32'h500 + n, "R4 irq epc next_pc", v, 32'h500 + n);
      rd(2'd1, v); chk(v == 0, "R9 tick cause", v, 0);
      do_eret(pc, sp, r);
      j = n + 5; e2 = (2*n + 1 > n + 5) ? 2*n + 1 : n + 5; #1;
      while (!redirect && j < 60) begin step(); j++; #1; end
      chk(j == e2, "R9 periodic tick", j, e2);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule